// File: doc/BRIEF.md
# Strobed Latch Decoder with Inhibit

This block turns a 4-bit binary code into a one-of-sixteen select vector. A hold stage sits in front of the decoder. While the strobe input is high, the hold stage passes the code straight through. When the strobe goes low, the stage keeps the last code it saw until the strobe rises again. An inhibit input blanks the decoded vector without disturbing the held code. A build-time parameter sets the output polarity. In the active-high option the selected line is 1. In the active-low option the selected line is 0.

A second build-time parameter picks how the hold stage is built. The default is a level-sensitive latch that is transparent while the strobe is high. The alternative is a register on the system clock. It loads at every rising clock edge where the strobe is high, so the outputs move one clock later. Both variants clear the held code to zero while reset is asserted.

Top module: `strobe_latch_decoder`

## Requirements
- R1: In the latch variant, while strobe is 1 the held code equals `din`, and the outputs follow `din` with no clock delay.
- R2: While strobe is 0, the held code keeps the value present when strobe last was 1. Changes on `din` then leave the outputs unchanged.
- R3: `din[3]` is the most significant bit. With inhibit at 0, code value k (0 to 15) selects output line `sel_out[k]`.
- R4: With inhibit at 0, exactly one of the sixteen output lines is at its active level.
- R5: With inhibit at 1, all sixteen lines are at their inactive level, whatever `din`, strobe or the held code are.
- R6: With POLARITY = POL_HIGH (the default), the active level is 1 and the inactive level is 0. With POL_LOW the active level is 0 and the inactive level is 1.
- R7: Inhibit does not alter the held code. When inhibit returns to 0, the code held before or during the inhibit is selected again.
- R8: In the clocked variant, the held code takes `din` at each rising clock edge where strobe is 1, and keeps its value at edges where strobe is 0. The outputs therefore change one clock after the loading edge.
- R9: `rst` (active high) clears the held code to 0. After reset is released with strobe at 0, line 0 is selected.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock: loads the clocked variant and samples the checks |
| rst | input | 1 | Active-high reset; clears the held code |
| strobe | input | 1 | 1 = pass or load `din`, 0 = hold |
| inhibit | input | 1 | 1 = force every output line inactive |
| din | input | 4 | Binary code, bit 3 most significant |
| sel_out | output | 16 | Decoded select lines, polarity set by POLARITY |

## Verification
The only state in this block is the held code. A wrong held value shows at the ports as the wrong line selected, or as a second line active. In the latch variant this is visible as soon as the strobe is low. In the clocked variant it is visible one clock after the edge that should have loaded or kept the code. The bench targets the cases where a faulty hold stage shows up: data that changes while the strobe is low, and inhibit that is asserted and then released over a held code. It also sweeps every code through the pass, hold and inhibit paths in both polarities, so a swapped bit weight or an inverted level shows at the ports right away.

// File: rtl/sld_pkg.sv
package sld_pkg;

    // Output polarity of the select lines
    typedef enum logic {
        POL_HIGH = 1'b0,
        POL_LOW  = 1'b1
    } pol_e;

    // Construction of the code hold stage
    typedef enum logic {
        HOLD_LATCH   = 1'b0,
        HOLD_CLOCKED = 1'b1
    } hold_e;

endpackage

// File: rtl/sld_code_hold.sv
module sld_code_hold
    import sld_pkg::*;
#(
    parameter int    SEL_W   = 4,
    parameter hold_e VARIANT = HOLD_LATCH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic [SEL_W-1:0] din,
    output logic [SEL_W-1:0] code
);

    typedef struct packed {
        logic [SEL_W-1:0] code;
    } hold_t;

    hold_t hold_d, hold_q;

    generate
        if (VARIANT == HOLD_CLOCKED) begin : g_reg
            always_comb begin
                hold_d = hold_q;
                if (rst) begin
                    hold_d.code = '0;
                end else if (strobe) begin
                    hold_d.code = din;
                end
            end

            always_ff @(posedge clk) begin
                hold_q <= hold_d;
            end

            // R8: a strobed edge loads the code presented at that edge
            p_load_r8: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && $past(strobe)) |-> (code == $past(din)));

            // R2: an edge without strobe keeps the held code
            p_keep_r2: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(strobe)) |-> $stable(code));

            // R9: the first cycle after reset shows code zero
            p_clear_r9: assert property (@(posedge clk) disable iff (rst)
                $past(rst) |-> (code == '0));
        end else begin : g_latch
            always_comb begin
                hold_d.code = rst ? '0 : din;
            end

            always_latch begin
                if (rst || strobe) begin
                    hold_q <= hold_d;
                end
            end

            // R1: transparent while strobe is high
            p_follow_r1: assert property (@(posedge clk) disable iff (rst)
                strobe |-> (code == din));

            // R2: no movement while strobe stays low
            p_keep_r2: assert property (@(posedge clk) disable iff (rst)
                (!$past(rst) && !$past(strobe) && !strobe) |-> $stable(code));

            // R9: reset leaves code zero when strobe stays low
            p_clear_r9: assert property (@(posedge clk) disable iff (rst)
                ($past(rst) && !$past(strobe) && !strobe) |-> (code == '0));
        end
    endgenerate

    assign code = hold_q.code;

endmodule

// File: rtl/sld_onehot.sv
module sld_onehot #(
    parameter int SEL_W = 4,
    localparam int OUT_W = 1 << SEL_W
) (
    input  logic [SEL_W-1:0] code,
    output logic [OUT_W-1:0] onehot
);

    generate
        for (genvar i = 0; i < OUT_W; i++) begin : g_line
            assign onehot[i] = (code == SEL_W'(i));
        end
    endgenerate

endmodule

// File: rtl/sld_drive.sv
module sld_drive
    import sld_pkg::*;
#(
    parameter int   SEL_W    = 4,
    parameter pol_e POLARITY = POL_HIGH,
    localparam int  OUT_W    = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inhibit,
    input  logic [SEL_W-1:0] code,
    input  logic [OUT_W-1:0] onehot,
    output logic [OUT_W-1:0] sel_out
);

    logic [OUT_W-1:0] gated;
    logic [OUT_W-1:0] active;

    assign gated = inhibit ? '0 : onehot;

    generate
        if (POLARITY == POL_LOW) begin : g_low
            assign sel_out = ~gated;
            assign active  = ~sel_out;
        end else begin : g_high
            assign sel_out = gated;
            assign active  = sel_out;
        end
    endgenerate

    localparam int ONES_LIVE = (POLARITY == POL_LOW) ? OUT_W - 1 : 1;
    localparam int ONES_IDLE = (POLARITY == POL_LOW) ? OUT_W : 0;

    // R4: exactly one line active when not inhibited
    p_one_active_r4: assert property (@(posedge clk) disable iff (rst)
        !inhibit |-> ($countones(active) == 1));

    // R3: the active line index equals the held code
    p_index_r3: assert property (@(posedge clk) disable iff (rst)
        !inhibit |-> active[code]);

    // R5: inhibit blanks every line
    p_blank_r5: assert property (@(posedge clk) disable iff (rst)
        inhibit |-> ($countones(sel_out) == ONES_IDLE));

    // R6: level count matches the chosen polarity
    p_level_r6: assert property (@(posedge clk) disable iff (rst)
        !inhibit |-> ($countones(sel_out) == ONES_LIVE));

endmodule

// File: rtl/strobe_latch_decoder.sv
module strobe_latch_decoder
    import sld_pkg::*;
#(
    parameter int    SEL_W    = 4,
    parameter pol_e  POLARITY = POL_HIGH,
    parameter hold_e VARIANT  = HOLD_LATCH,
    localparam int   OUT_W    = 1 << SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             strobe,
    input  logic             inhibit,
    input  logic [SEL_W-1:0] din,
    output logic [OUT_W-1:0] sel_out
);

    logic [SEL_W-1:0] held_code;
    logic [OUT_W-1:0] onehot;

    sld_code_hold #(
        .SEL_W   (SEL_W),
        .VARIANT (VARIANT)
    ) u_hold (
        .clk    (clk),
        .rst    (rst),
        .strobe (strobe),
        .din    (din),
        .code   (held_code)
    );

    sld_onehot #(
        .SEL_W (SEL_W)
    ) u_onehot (
        .code   (held_code),
        .onehot (onehot)
    );

    sld_drive #(
        .SEL_W    (SEL_W),
        .POLARITY (POLARITY)
    ) u_drive (
        .clk     (clk),
        .rst     (rst),
        .inhibit (inhibit),
        .code    (held_code),
        .onehot  (onehot),
        .sel_out (sel_out)
    );

endmodule

// File: tb/test_strobe_latch_decoder.sv
module test_strobe_latch_decoder;
    import sld_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        strobe = 1'b0;
    logic        inhibit = 1'b0;
    logic [3:0]  din = 4'd5;
    logic [15:0] out_hi, out_lo, out_clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int t_held = 0;
    int c_held = 0;

    always #10 clk = ~clk;

    strobe_latch_decoder i_strobe_latch_decoder (
        .clk(clk), .rst(rst), .strobe(strobe), .inhibit(inhibit),
        .din(din), .sel_out(out_hi));

    strobe_latch_decoder #(.POLARITY(POL_LOW)) i_strobe_latch_decoder_low (
        .clk(clk), .rst(rst), .strobe(strobe), .inhibit(inhibit),
        .din(din), .sel_out(out_lo));

    strobe_latch_decoder #(.VARIANT(HOLD_CLOCKED)) i_strobe_latch_decoder_clk (
        .clk(clk), .rst(rst), .strobe(strobe), .inhibit(inhibit),
        .din(din), .sel_out(out_clk));

    function automatic logic [15:0] expv(int code, bit inh, bit low);
        logic [15:0] v;
        v = inh ? 16'h0000 : (16'h0001 << code);
        return low ? ~v : v;
    endfunction

    task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // Apply inputs at a falling edge, check latch outputs at once,
    // check the clocked variant after the next rising edge.
    task automatic step(int d, bit s, bit inh, string tag);
        din = 4'(d);
        strobe = s;
        inhibit = inh;
        if (s) t_held = d;
        #1;
        check({tag, " high"}, out_hi, expv(t_held, inh, 1'b0));
        check({tag, " low"},  out_lo, expv(t_held, inh, 1'b1));
        @(negedge clk);
        if (s) c_held = d;
        check({tag, " R8 clocked"}, out_clk, expv(c_held, inh, 1'b0));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R9 reset high", out_hi, expv(0, 1'b0, 1'b0));
        check("R9 reset low",  out_lo, expv(0, 1'b0, 1'b1));
        check("R9 reset clocked", out_clk, expv(0, 1'b0, 1'b0));
        @(negedge clk);

        // R1 R3 R4 R6: pass-through sweep of every code
        for (int k = 0; k < 16; k++) step(k, 1'b1, 1'b0, "R1 R3 R4 R6 sweep");

        // R2: data moving while strobe is low, every code
        for (int k = 0; k < 16; k++) begin
            step(k, 1'b1, 1'b0, "R2 load");
            step(15 - k, 1'b0, 1'b0, "R2 hold");
            step((k + 7) % 16, 1'b0, 1'b0, "R2 hold again");
        end

        // R5 R7: inhibit over a held code, then release
        step(9, 1'b1, 1'b0, "R7 load");
        step(9, 1'b0, 1'b0, "R7 fall");
        step(12, 1'b0, 1'b1, "R5 blank held");
        step(6, 1'b0, 1'b0, "R7 restore");

        // R5 R7: inhibit while strobe high still loads the code
        step(14, 1'b1, 1'b1, "R5 blank strobed");
        step(1, 1'b0, 1'b1, "R5 blank still");
        step(1, 1'b0, 1'b0, "R7 reappear");

        // R5: inhibit over every code
        for (int k = 0; k < 16; k++) step(k, k[0], 1'b1, "R5 sweep");
        step(3, 1'b0, 1'b0, "R7 after sweep");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule